// File: doc/BRIEF.md
# Write-Only Serial Command/Data Receiver

This block is the four-wire serial front end of a dot-matrix display controller. A host drives a serial clock, a serial data line, an active-low select and a sideband line that marks each byte as display data or as a command. The block brings these pins into the system clock domain and assembles eight-bit bytes, most significant bit first. It hands each finished byte to the controller on one of two single-cycle strobes. The command strobe feeds the command decoder. The data strobe feeds display memory.

The link only carries writes, so there is no return path. Three strap inputs choose the host interface. The receiver runs only when the straps select four-wire serial. Every other strap code keeps it idle. The outgoing byte is a valid-only stream with no ready signal, so the block cannot apply back-pressure. A consumer must accept a strobe in the cycle it appears. At most one byte arrives every eight serial clocks.

Top module: `serial_dc_rx`

## Requirements
- R1: While reset is low, and until the first complete byte after reset, both strobes stay low.
- R2: Eight rising serial clock edges with select low form one byte. The bit sampled first becomes bit 7 of `rx_byte`.
- R3: A finished byte raises `dat_stb` when the data/command line is 1, and `cmd_stb` when that line is 0.
- R4: The data/command line is sampled only at the eighth rising edge of a byte. Its level during the first seven edges has no effect.
- R5: Raising select in the middle of a byte drops the partial byte. The next byte after select returns low is assembled from its own eight bits.
- R6: Serial clock edges while select is high produce no strobe and do not advance the bit count.
- R7: Only strap code `ifsel = 3'b000` enables the receiver. Bit 0 of this code is the first strap. The other seven codes produce no strobe and keep the bit count at zero.
- R8: Each strobe lasts exactly one system clock cycle. The two strobes are never high together.
- R9: While select stays low, consecutive bytes are delivered back to back with no gap bits between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ifsel | input | 3 | Interface-select straps; 000 means four-wire serial |
| ser_clk | input | 1 | Serial clock from host, idle low |
| ser_din | input | 1 | Serial data from host |
| sel_n | input | 1 | Active-low chip select |
| dc_sel | input | 1 | 1 = display data, 0 = command |
| rx_byte | output | 8 | Last assembled byte, valid with a strobe |
| cmd_stb | output | 1 | One-cycle strobe: `rx_byte` is a command |
| dat_stb | output | 1 | One-cycle strobe: `rx_byte` is display data |

## Verification
The main sweep sends all 256 byte values, each once as data and once as a command. During the first seven bits the data/command line is driven to the opposite level, so a bit-order error, an early sample of that line or a wrong strobe choice each shows up. A byte cut short by select, a full byte clocked with select high, and all seven non-serial strap codes are each followed by a clean byte. This shows whether a stray edge advanced the counter. Back-to-back bytes under one select window show whether byte framing stays aligned.

// File: rtl/serial_dc_rx_pkg.sv
package serial_dc_rx_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    IF_SER4  = 3'b000,
    IF_SER3  = 3'b001,
    IF_TWI   = 3'b010,
    IF_PAR68 = 3'b100,
    IF_PAR80 = 3'b110
  } ifsel_e;
endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{rst_val[b]}};
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              dc_s,
  output logic [BYTE_W-1:0] byte_q,
  output logic              cmd_q,
  output logic              dat_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_d;
  logic              rise;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] next_sh;

  assign rise    = sclk_s & ~sclk_d;
  assign next_sh = {sh[BYTE_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      byte_q <= '0;
      cmd_q  <= 1'b0;
      dat_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cmd_q  <= 1'b0;
      dat_q  <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (rise) begin
        sh <= next_sh;
        if (cnt == LAST) begin
          cnt    <= '0;
          byte_q <= next_sh;
          dat_q  <= dc_s;
          cmd_q  <= ~dc_s;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_q && dat_q)); // R8
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q |=> !cmd_q); // R8
  AST_DAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_q |=> !dat_q); // R8
  AST_STB_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q || dat_q) |-> $past(run && sclk_s && !sclk_d)); // R6
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R5
endmodule

// File: rtl/serial_dc_rx.sv
module serial_dc_rx
  import serial_dc_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ifsel,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              sel_n,
  input  logic              dc_sel,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              cmd_stb,
  output logic              dat_stb
);
  logic [3:0] raw, synced;
  logic       mode_ok;
  logic       run;

  assign raw     = {dc_sel, sel_n, ser_din, ser_clk};
  assign mode_ok = (ifsel == IF_SER4);
  assign run     = mode_ok & ~synced[2];

  sdr_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw),
    .rst_val  (4'b0100),
    .sync_out (synced)
  );

  sdr_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sclk_s (synced[0]),
    .din_s  (synced[1]),
    .dc_s   (synced[3]),
    .byte_q (rx_byte),
    .cmd_q  (cmd_stb),
    .dat_q  (dat_stb)
  );

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb || dat_stb) |-> $past(ifsel == IF_SER4)); // R7
endmodule

// File: tb/tb_serial_dc_rx.sv
module tb_serial_dc_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ifsel = 3'b000;
  logic       ser_clk = 1'b0, ser_din = 1'b0, sel_n = 1'b1, dc_sel = 1'b0;
  logic [7:0] rx_byte;
  logic       cmd_stb, dat_stb;

  int n_cmp = 0, n_bad = 0;
  int n_cmd = 0, n_dat = 0, n_both = 0;
  logic [7:0] last_b = 8'h00;

  always #10 clk = ~clk;

  serial_dc_rx dut (.*);

  always @(negedge clk) begin
    if (cmd_stb) begin n_cmd++; last_b = rx_byte; end
    if (dat_stb) begin n_dat++; last_b = rx_byte; end
    if (cmd_stb && dat_stb) n_both++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input logic dc);
    for (int i = 7; i > 7 - n; i--) begin
      ser_din = b[i];
      dc_sel  = (i == 0) ? dc : ~dc;
      clks(4);
      ser_clk = 1'b1;
      clks(4);
      ser_clk = 1'b0;
    end
  endtask

  task automatic expect_byte(input logic [7:0] b, input logic dc, input string req);
    int c0, d0;
    c0 = n_cmd; d0 = n_dat;
    send_bits(b, 8, dc);
    clks(8);
    chk(last_b == b, req, last_b, b);
    chk((n_dat - d0) == (dc ? 1 : 0) && (n_cmd - c0) == (dc ? 0 : 1),
        {req, "/R3/R4 kind"}, n_dat - d0, dc ? 1 : 0);
  endtask

  task automatic expect_none(input int n, input string req);
    int c0, d0;
    c0 = n_cmd; d0 = n_dat;
    send_bits(8'hFF, n, 1'b1);
    clks(8);
    chk(n_cmd == c0 && n_dat == d0, req, (n_cmd - c0) + (n_dat - d0), 0);
  endtask

  initial begin
    #(20 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clks(3);
    chk(cmd_stb == 1'b0 && dat_stb == 1'b0, "R1 in reset", {cmd_stb, dat_stb}, 0);
    rst_n = 1'b1;
    clks(10);
    chk(n_cmd == 0 && n_dat == 0, "R1 after reset", n_cmd + n_dat, 0);

    sel_n = 1'b0;
    clks(4);
    for (int v = 0; v < 256; v++)
      for (int d = 0; d < 2; d++)
        expect_byte(8'(v), 1'(d), "R2 sweep");

    send_bits(8'h00, 3, 1'b0);
    sel_n = 1'b1; clks(8); sel_n = 1'b0; clks(4);
    expect_byte(8'hA5, 1'b1, "R5 after partial");

    sel_n = 1'b1; clks(4);
    expect_none(8, "R6 select high");
    sel_n = 1'b0; clks(4);
    expect_byte(8'h3C, 1'b0, "R6 count held");

    for (int s = 1; s < 8; s++) begin
      ifsel = 3'(s);
      clks(2);
      expect_none(5, "R7 strap");
      ifsel = 3'b000;
      clks(4);
      expect_byte(8'(8'h11 * s), 1'(s[0]), "R7 count cleared");
    end

    expect_byte(8'h81, 1'b1, "R9 first");
    expect_byte(8'h7E, 1'b0, "R9 second");
    expect_byte(8'hC3, 1'b1, "R9 third");

    chk(n_both == 0, "R8 exclusive strobes", n_both, 0);
    sel_n = 1'b1;
    clks(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule